// File: doc/BRIEF.md
# Register stack spill/fill engine

This block keeps a circular file of stacked physical registers usable by arbitrarily deep call nesting. The frame manager asks for room with an allocation request, which grows the live region by a frame size. It gives room back with a return request, which names the callee frame size to release and the caller frame size that must be resident afterwards. The static registers of the machine sit outside the circular file and are never visible here.

When an allocation needs more registers than are free, the engine raises a stall. While the stall is up, it copies the oldest live registers to a backing store in memory as burst writes, and the backing-store pointer moves up one 64-bit word per register. When a return finds part of the caller frame missing from the file, it stalls the return. The most recently saved words are then read back first, as burst reads, into the slots just below the oldest resident register, and the pointer moves down one word per register. Memory traffic runs only while one of the two stalls is pending, so unrelated work is never held up by the engine.

Top module: `reg_stack_engine`

## Requirements
- R1: After reset the live count is 0, the backing-store pointer equals the base parameter (default 0x1000), no memory request is raised and neither stall is asserted.
- R2: `alloc_stall` is high exactly when `alloc_req` is high and `alloc_size` exceeds NREG minus the live count. An allocation accepted at a clock edge (request high, stall low) adds `alloc_size` to the live count.
- R3: Each spill beat reads register slot `rf_raddr` equal to the oldest resident slot and writes its data to byte address `mem_addr` equal to the backing-store pointer. After the beat the pointer has risen by 8, the live count has dropped by 1 and the oldest slot has advanced by one.
- R4: Every burst carries `mem_len` equal to the smaller of BURST (default 8) and the number of registers still missing, so a final burst may be partial. Spill bursts have `mem_we`=1 and fill bursts have `mem_we`=0.
- R5: The allocation stall drops in the first cycle in which the free count (NREG minus live count) reaches `alloc_size`, which is the cycle after the edge of the last needed spill beat.
- R6: `ret_stall` is high exactly when `ret_req` is high and `ret_pop`+`ret_need` exceeds the live count. An accepted return subtracts `ret_pop` from the live count.
- R7: Fill is last-in first-out. Each fill beat reads byte address pointer−8 and writes `mem_rdata` into the slot just below the oldest resident slot. After the beat the pointer has fallen by 8 and the live count has risen by 1. After the return completes, the caller frame holds the values that were spilled.
- R8: Slot indices wrap modulo NREG in both directions (slot NREG−1 is followed by slot 0 on spill and preceded by it on fill), and every register-file address stays below NREG.
- R9: No memory request is issued when neither stall is pending; an allocation or return that fits causes no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request, held until accepted |
| alloc_size | input | 7 | Registers the new frame adds |
| alloc_stall | output | 1 | Allocation cannot be accepted yet |
| ret_req | input | 1 | Return request, held until accepted |
| ret_pop | input | 7 | Registers released by the returning frame |
| ret_need | input | 7 | Caller frame size that must be resident |
| ret_stall | output | 1 | Return cannot be accepted yet |
| dirty_cnt | output | 7 | Live resident register count |
| bsp | output | 32 | Backing-store byte pointer (next free word) |
| rf_raddr | output | 7 | Register-file read slot for spills |
| rf_rdata | input | 64 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe for fills |
| rf_waddr | output | 7 | Register-file write slot |
| rf_wdata | output | 64 | Register-file write data |
| mem_req | output | 1 | Burst request, held until acknowledged |
| mem_we | output | 1 | 1 = burst write (spill), 0 = burst read (fill) |
| mem_len | output | 4 | Beats in the requested burst |
| mem_addr | output | 32 | Byte address of the current beat |
| mem_ack | input | 1 | Burst request accepted |
| mem_beat | input | 1 | One data beat completes at this edge |
| mem_wdata | output | 64 | Spill beat data |
| mem_rdata | input | 64 | Fill beat data |

## Verification
The two events that share a cycle boundary are the last beat of a burst and the release of the pending allocation or return. That beat edge updates the live count, and the stall must fall in the very next cycle so that acceptance lands one edge later. The bench provokes this with frame sizes whose shortfall is a whole number of bursts, a partial remainder, or a single register, and with a memory that inserts idle cycles between beats. Each cycle it compares both stall outputs against the free count it derives from the beats it has granted, and it checks the live count and pointer after each acceptance.

// File: rtl/reg_stack_engine.sv
module reg_stack_engine #(
  parameter int NREG = 96,
  parameter int DW = 64,
  parameter int AW = 32,
  parameter int BURST = 8,
  parameter logic [31:0] BSP_BASE = 32'h0000_1000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_req,
  input  logic [$clog2(NREG+1)-1:0]      alloc_size,
  output logic                           alloc_stall,
  input  logic                           ret_req,
  input  logic [$clog2(NREG+1)-1:0]      ret_pop,
  input  logic [$clog2(NREG+1)-1:0]      ret_need,
  output logic                           ret_stall,
  output logic [$clog2(NREG+1)-1:0]      dirty_cnt,
  output logic [AW-1:0]                  bsp,
  output logic [$clog2(NREG)-1:0]        rf_raddr,
  input  logic [DW-1:0]                  rf_rdata,
  output logic                           rf_we,
  output logic [$clog2(NREG)-1:0]        rf_waddr,
  output logic [DW-1:0]                  rf_wdata,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [$clog2(BURST+1)-1:0]     mem_len,
  output logic [AW-1:0]                  mem_addr,
  input  logic                           mem_ack,
  input  logic                           mem_beat,
  output logic [DW-1:0]                  mem_wdata,
  input  logic [DW-1:0]                  mem_rdata
);
  localparam int IW = $clog2(NREG);
  localparam int CW = $clog2(NREG+1);
  localparam int LW = $clog2(BURST+1);
  localparam int NB = DW/8;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_BEAT} st_t;
  st_t st;

  logic [IW-1:0] head;
  logic [CW-1:0] dirty, dirty_nx;
  logic [AW-1:0] bsp_q;
  logic          spill_dir;
  logic [LW-1:0] len_q, cnt;

  logic [CW:0] free_w, ret_sum, need_s, need_f;
  logic [LW-1:0] len_s, len_f;
  logic [IW-1:0] head_up, head_dn;
  logic beat, alloc_ok, ret_ok;

  assign free_w  = (CW+1)'(NREG) - {1'b0, dirty};
  assign ret_sum = {1'b0, ret_pop} + {1'b0, ret_need};
  assign need_s  = {1'b0, alloc_size} - free_w;
  assign need_f  = ret_sum - {1'b0, dirty};
  assign len_s   = (need_s > (CW+1)'(BURST)) ? LW'(BURST) : LW'(need_s);
  assign len_f   = (need_f > (CW+1)'(BURST)) ? LW'(BURST) : LW'(need_f);

  assign alloc_stall = alloc_req && ({1'b0, alloc_size} > free_w);
  assign ret_stall   = ret_req && (ret_sum > {1'b0, dirty});
  assign alloc_ok    = alloc_req && !alloc_stall;
  assign ret_ok      = ret_req && !ret_stall;

  assign head_up = (head == IW'(NREG-1)) ? '0 : head + 1'b1;
  assign head_dn = (head == '0) ? IW'(NREG-1) : head - 1'b1;
  assign beat    = (st == S_BEAT) && mem_beat;

  assign rf_raddr  = head;
  assign mem_wdata = rf_rdata;
  assign rf_we     = beat && !spill_dir;
  assign rf_waddr  = head_dn;
  assign rf_wdata  = mem_rdata;
  assign mem_req   = (st == S_REQ);
  assign mem_we    = spill_dir;
  assign mem_len   = len_q;
  assign mem_addr  = spill_dir ? bsp_q : bsp_q - AW'(NB);
  assign dirty_cnt = dirty;
  assign bsp       = bsp_q;

  always_comb begin
    dirty_nx = dirty;
    if (alloc_ok) dirty_nx = dirty_nx + alloc_size;
    if (ret_ok)   dirty_nx = dirty_nx - ret_pop;
    if (beat)     dirty_nx = spill_dir ? dirty_nx - 1'b1 : dirty_nx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      head      <= '0;
      dirty     <= '0;
      bsp_q     <= AW'(BSP_BASE);
      spill_dir <= 1'b0;
      len_q     <= '0;
      cnt       <= '0;
    end else begin
      dirty <= dirty_nx;
      if (beat) begin
        head  <= spill_dir ? head_up : head_dn;
        bsp_q <= spill_dir ? bsp_q + AW'(NB) : bsp_q - AW'(NB);
      end
      case (st)
        S_IDLE:
          if (alloc_stall) begin
            spill_dir <= 1'b1;
            len_q     <= len_s;
            st        <= S_REQ;
          end else if (ret_stall) begin
            spill_dir <= 1'b0;
            len_q     <= len_f;
            st        <= S_REQ;
          end
        S_REQ:
          if (mem_ack) begin
            cnt <= len_q;
            st  <= S_BEAT;
          end
        default:
          if (mem_beat) begin
            cnt <= cnt - 1'b1;
            if (cnt == LW'(1)) st <= S_IDLE;
          end
      endcase
    end
  end

  AST_RF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_raddr < IW'(NREG)) && (rf_waddr < IW'(NREG))); // R8
  AST_LIVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_cnt <= CW'(NREG)); // R2
  AST_SPILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && spill_dir) |=> (bsp == $past(bsp) + AW'(NB)) && (dirty_cnt == $past(dirty_cnt) - 1'b1)); // R3
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !spill_dir) |=> (bsp == $past(bsp) - AW'(NB)) && (dirty_cnt == $past(dirty_cnt) + 1'b1)); // R7
  AST_FILL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !spill_dir) |-> (bsp > AW'(BSP_BASE))); // R7
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0) && (mem_len <= LW'(BURST))); // R4
  AST_REQ_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (alloc_stall || ret_stall)); // R9
endmodule

// File: tb/reg_stack_engine_bench.sv
`timescale 1ns/1ps
module reg_stack_engine_bench;
  localparam int NREG = 96;
  localparam int BURST = 8;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        alloc_req = 1'b0, ret_req = 1'b0;
  logic [6:0]  alloc_size = '0, ret_pop = '0, ret_need = '0;
  logic        alloc_stall, ret_stall;
  logic [6:0]  dirty_cnt;
  logic [31:0] bsp;
  logic [6:0]  rf_raddr, rf_waddr;
  logic [63:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic        mem_req, mem_we;
  logic [3:0]  mem_len;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0, mem_beat = 1'b0;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;

  reg_stack_engine u_reg_stack_engine (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_size(alloc_size), .alloc_stall(alloc_stall),
    .ret_req(ret_req), .ret_pop(ret_pop), .ret_need(ret_need), .ret_stall(ret_stall),
    .dirty_cnt(dirty_cnt), .bsp(bsp),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_len(mem_len), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_beat(mem_beat), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int errors = 0, checks = 0;
  int cyc = 0;
  bit done = 0;

  logic [63:0] rf   [0:NREG-1];
  logic [63:0] mem  [0:511];
  logic [63:0] tagv [0:511];
  logic        tb_we = 1'b0;
  logic [6:0]  tb_waddr = '0;
  logic [63:0] tb_wdata = '0;

  int dm = 0, lb = 0, gen = 0, nf = 0;
  int frames [0:31];
  int cur_op = 0, cur_size = 0, cur_pop = 0, cur_need = 0;
  int bursts = 0, rem = 0, len_l = 0;
  bit busy = 0, we_l = 0;

  assign rf_rdata = rf[rf_raddr];

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    else if (tb_we) rf[tb_waddr] <= tb_wdata;
  end

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic int min8(input int n);
    return (n > BURST) ? BURST : n;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_beat) begin
        if (we_l) begin lb++; dm--; end
        else begin lb--; dm++; end
      end
      mem_beat = 1'b0;
      if (mem_ack) begin
        mem_ack = 1'b0; busy = 1; rem = len_l;
      end else if (busy) begin
        if (rem == 0) busy = 0;
        else if ((cyc % 4) != 3) begin
          if (we_l) begin
            chk(rf_raddr == 7'(lb % NREG), "R8 spill slot", rf_raddr, lb % NREG);
            chk(mem_addr == BASE + 32'(8*lb), "R3 spill addr", mem_addr, BASE + 32'(8*lb));
            chk(mem_wdata == tagv[lb], "R3 spill data", mem_wdata, tagv[lb]);
            mem[lb] = mem_wdata;
          end else begin
            chk(mem_addr == BASE + 32'(8*(lb-1)), "R7 fill addr", mem_addr, BASE + 32'(8*(lb-1)));
            chk(rf_waddr == 7'((lb-1) % NREG), "R8 fill slot", rf_waddr, (lb-1) % NREG);
            mem_rdata = mem[lb-1];
          end
          mem_beat = 1'b1;
          rem--;
        end
      end else if (mem_req) begin
        int need;
        need = (cur_op == 1) ? cur_size - (NREG - dm) : cur_pop + cur_need - dm;
        chk(mem_len == 4'(min8(need)), "R4 burst length", mem_len, min8(need));
        chk(mem_we == (cur_op == 1), "R4 burst direction", mem_we, cur_op == 1);
        len_l = mem_len; we_l = mem_we;
        bursts++;
        mem_ack = 1'b1;
      end
    end
  end

  task automatic tag_frame(input int size);
    int top;
    top = lb + dm;
    for (int l = top - size; l < top; l++) begin
      tagv[l] = {16'(gen), 16'hC0DE, 32'(l)};
      tb_we = 1'b1; tb_waddr = 7'(l % NREG); tb_wdata = tagv[l];
      @(negedge clk);
    end
    tb_we = 1'b0;
  endtask

  task automatic do_alloc(input int size);
    int need, expb, b0;
    bit exp_st;
    cur_op = 1; cur_size = size;
    need = size - (NREG - dm);
    expb = (need > 0) ? (need + BURST - 1) / BURST : 0;
    b0 = bursts;
    alloc_size = 7'(size); alloc_req = 1'b1;
    forever begin
      #1;
      exp_st = size > NREG - dm;
      chk(alloc_stall == exp_st, exp_st ? "R2 alloc stall" : "R5 alloc release", alloc_stall, exp_st);
      if (!alloc_stall) break;
      @(negedge clk);
    end
    @(posedge clk);
    dm += size;
    @(negedge clk);
    alloc_req = 1'b0;
    #1;
    chk(dirty_cnt == 7'(dm), "R2 live count", dirty_cnt, dm);
    chk(bsp == BASE + 32'(8*lb), "R3 pointer", bsp, BASE + 32'(8*lb));
    chk(bursts - b0 == expb, (expb == 0) ? "R9 no burst" : "R4 burst count", bursts - b0, expb);
    frames[nf] = size; nf++;
    @(negedge clk);
    tag_frame(size);
  endtask

  task automatic do_ret;
    int need, expb, b0, bad, top;
    bit exp_st;
    cur_op = 2;
    cur_pop = frames[nf-1];
    cur_need = (nf > 1) ? frames[nf-2] : 0;
    need = cur_pop + cur_need - dm;
    expb = (need > 0) ? (need + BURST - 1) / BURST : 0;
    b0 = bursts;
    ret_pop = 7'(cur_pop); ret_need = 7'(cur_need); ret_req = 1'b1;
    forever begin
      #1;
      exp_st = cur_pop + cur_need > dm;
      chk(ret_stall == exp_st, "R6 return stall", ret_stall, exp_st);
      if (!ret_stall) break;
      @(negedge clk);
    end
    @(posedge clk);
    dm -= cur_pop;
    @(negedge clk);
    ret_req = 1'b0;
    #1;
    nf--;
    chk(dirty_cnt == 7'(dm), "R6 live count", dirty_cnt, dm);
    chk(bsp == BASE + 32'(8*lb), "R7 pointer", bsp, BASE + 32'(8*lb));
    chk(bursts - b0 == expb, (expb == 0) ? "R9 no burst" : "R4 burst count", bursts - b0, expb);
    bad = 0;
    top = lb + dm;
    for (int l = top - cur_need; l < top; l++)
      if (rf[l % NREG] != tagv[l]) bad++;
    chk(bad == 0, "R7 caller frame restored", bad, 0);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) rf[i] = 64'hDEAD_0000_0000_0000 | 64'(i);
    for (int i = 0; i < 512; i++) begin mem[i] = '0; tagv[i] = '0; end
    repeat (4) @(negedge clk);
    #1;
    chk(dirty_cnt == 0, "R1 reset live count", dirty_cnt, 0);
    chk(bsp == BASE, "R1 reset pointer", bsp, BASE);
    chk(mem_req == 0, "R1 reset request", mem_req, 0);
    chk(alloc_stall == 0 && ret_stall == 0, "R1 reset stalls", {alloc_stall, ret_stall}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    gen = 0;
    do_alloc(10); do_alloc(20); do_alloc(30); do_alloc(36);
    do_alloc(1); do_alloc(19); do_alloc(40); do_alloc(50); do_alloc(46);
    while (nf > 0) do_ret;

    gen = 1;
    do_alloc(60); do_alloc(36); do_alloc(60); do_ret;
    do_alloc(25); do_alloc(70);
    while (nf > 0) do_ret;

    gen = 2;
    do_alloc(96); do_ret;
    do_alloc(48); do_alloc(48); do_alloc(48); do_alloc(16); do_alloc(80);
    while (nf > 0) do_ret;

    #1;
    chk(dirty_cnt == 0 && bsp == BASE, "R8 fully unwound", {dirty_cnt, bsp}, {7'd0, BASE});
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule